// File: doc/BRIEF.md
# Floating-point and vector instruction permission gate

This block sits between instruction issue and execution. For each issued instruction it gets a class code and gives a verdict in the same cycle. The verdict is either permission to run or a fault with a vector number. The verdict depends on a few control bits that the block keeps, taken from the writes software makes to the two system control registers. These bits are:

- emulation request
- wait-monitor
- task-switched
- the OS bits that enable SSE state, SSE numeric exceptions and extended state save

The task-switched flag has its own two sources. A hardware task switch sets it, and a dedicated clear instruction clears it. Because the flag is switched lazily, the operating system can save floating-point state only when a later instruction actually uses it. The block does not decode instructions and does not deliver the faults it reports.

Execution reports SSE numeric exceptions back to the block. If the OS has enabled them, the block turns such a report into a SIMD-exception fault. If not, the report disables SSE: every later SSE instruction faults as invalid until software writes control register 4 again.

Top module: `fpu_perm_gate`

## Requirements
- R1: After synchronous active-low reset all kept control bits are clear. With those bits clear, x87 arithmetic (class 0), wait (class 1) and MMX (class 2) are allowed. SSE (class 3) and extended save (class 4) fault with vector 6.
- R2: With CR0 bit 2 set, classes 0, 2, 3 and 4 fault with vector 6 (invalid opcode). This takes precedence over the task-switched fault.
- R3: With CR0 bit 3 (task-switched) set and no invalid-opcode condition, classes 0, 2, 3 and 4 fault with vector 7 (device not available).
- R4: Wait (class 1) ignores CR0 bit 2. It faults with vector 7 only when both CR0 bit 1 and the task-switched flag are set, and is allowed otherwise.
- R5: SSE (class 3) faults with vector 6 while CR4 bit 9 is clear.
- R6: Extended save (class 4) faults with vector 6 while CR4 bit 18 is clear.
- R7: The task-switched flag takes its next value by priority: a task-switch strobe sets it; otherwise a clear strobe clears it; otherwise a CR0 write loads it from data bit 3. Any change is seen from the next cycle.
- R8: An SSE exception report while CR4 bit 10 is set gives fault_valid with vector 19 in that same cycle. A concurrent issue then gets neither allow nor a fault of its own.
- R9: An SSE exception report while CR4 bit 10 is clear gives no output. From the next cycle, SSE (class 3) faults with vector 6. This lasts until a CR4 write or reset clears that state; a CR4 write in the same cycle as a report leaves SSE not disabled. Other classes are unaffected.
- R10: Classes 5 to 7 are always allowed. With neither issue nor an SSE report, allow and fault_valid are low. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | An instruction is issued this cycle |
| iclass | input | 3 | Class code of the issued instruction |
| task_sw | input | 1 | Hardware task switch strobe |
| clr_ts | input | 1 | Clear-task-switched instruction strobe |
| cr0_we | input | 1 | Control register 0 write strobe |
| cr0_wdata | input | 32 | Control register 0 write data |
| cr4_we | input | 1 | Control register 4 write strobe |
| cr4_wdata | input | 32 | Control register 4 write data |
| sse_exc | input | 1 | SSE numeric exception reported by execution |
| allow | output | 1 | Issued instruction may execute |
| fault_valid | output | 1 | One-cycle fault indication |
| fault_vec | output | 8 | Fault vector number (6, 7 or 19) |

## Verification
The hardest state to reach is the latched SSE-disabled condition. Reaching it takes a CR4 write that enables SSE with its exception bit clear, then a numeric exception report, then SSE issues that must now fault as invalid. An x87 issue in the middle must still be allowed. Directed stimulus builds this chain and then ends it with a CR4 write in the same cycle as a second report, to show that the clear wins. Random cycles with biased control writes then mix the latch with task switches and clear strobes, and a behavioural model is compared against the design on every cycle.

// File: rtl/fpg_pkg.sv
// Package for the permission gate.
// Contents: class codes, fault vector numbers, control bit positions
// and the struct of kept control bits.
// Assumes control register writes carry at least 19 bits.
package fpg_pkg;
    localparam int CLS_W = 3;
    localparam int VEC_W = 8;

    typedef enum logic [CLS_W-1:0] {
        CLS_X87   = 3'd0,
        CLS_WAIT  = 3'd1,
        CLS_MMX   = 3'd2,
        CLS_SSE   = 3'd3,
        CLS_XSAVE = 3'd4
    } iclass_e;

    localparam logic [VEC_W-1:0] VEC_UD = 8'd6;
    localparam logic [VEC_W-1:0] VEC_NM = 8'd7;
    localparam logic [VEC_W-1:0] VEC_XF = 8'd19;

    localparam int B_MP   = 1;
    localparam int B_EM   = 2;
    localparam int B_TS   = 3;
    localparam int B_FXSR = 9;
    localparam int B_XMM  = 10;
    localparam int B_XSV  = 18;

    typedef struct packed {
        logic mp;
        logic em;
        logic ts;
        logic fxsr;
        logic xmm;
        logic xsv;
        logic sse_off;
    } ctl_t;
endpackage

// File: rtl/fpg_ctrl_regs.sv
// Holds the control bits that the gate decides on.
// It also keeps the task-switched flag and the SSE-disabled latch.
// Assumes XLEN is wide enough to hold the highest bit position used.
module fpg_ctrl_regs
    import fpg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            task_sw,
    input  logic            clr_ts,
    input  logic            cr0_we,
    input  logic [XLEN-1:0] cr0_wdata,
    input  logic            cr4_we,
    input  logic [XLEN-1:0] cr4_wdata,
    input  logic            sse_exc,
    output ctl_t            ctl
);
    ctl_t ctl_q;
    logic unused_bits;

    // Fold away the write data bits that the gate does not keep.
    assign unused_bits = ^{cr0_wdata, cr4_wdata};

    // Update each kept bit from its write port or strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (cr0_we) begin
                ctl_q.mp <= cr0_wdata[B_MP];
                ctl_q.em <= cr0_wdata[B_EM];
            end
            if (task_sw)     ctl_q.ts <= 1'b1;
            else if (clr_ts) ctl_q.ts <= 1'b0;
            else if (cr0_we) ctl_q.ts <= cr0_wdata[B_TS];
            if (cr4_we) begin
                ctl_q.fxsr <= cr4_wdata[B_FXSR];
                ctl_q.xmm  <= cr4_wdata[B_XMM];
                ctl_q.xsv  <= cr4_wdata[B_XSV];
            end
            if (cr4_we)                    ctl_q.sse_off <= 1'b0;
            else if (sse_exc && !ctl_q.xmm) ctl_q.sse_off <= 1'b1;
        end
    end

    assign ctl = ctl_q;

    // R7
    ts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> ctl_q.ts);
    // R7
    ts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ts && !task_sw) |=> !ctl_q.ts);
    // R9
    sse_off_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr4_we |=> !ctl_q.sse_off);
    // R9
    sse_off_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sse_exc && !ctl_q.xmm && !cr4_we) |=> ctl_q.sse_off);
endmodule

// File: rtl/fpg_decide.sv
// Combinational verdict for one issue and the kept control bits.
// Gives either allow or a fault with its vector.
// An SSE exception report routed to the SIMD vector takes the cycle.
module fpg_decide
    import fpg_pkg::*;
(
    input  logic             issue,
    input  logic [CLS_W-1:0] iclass,
    input  logic             sse_exc,
    input  ctl_t             ctl,
    output logic             allow,
    output logic             fault_valid,
    output logic [VEC_W-1:0] fault_vec
);
    logic ud;
    logic nm;

    // Find the invalid-opcode and not-available conditions for the class.
    always_comb begin
        ud = 1'b0;
        nm = 1'b0;
        case (iclass_e'(iclass))
            CLS_WAIT:  nm = ctl.mp & ctl.ts;
            CLS_X87,
            CLS_MMX:   begin ud = ctl.em; nm = ctl.ts; end
            CLS_SSE:   begin ud = ctl.em | ~ctl.fxsr | ctl.sse_off; nm = ctl.ts; end
            CLS_XSAVE: begin ud = ctl.em | ~ctl.xsv; nm = ctl.ts; end
            default:   ;
        endcase
    end

    // Pick the verdict by priority: SIMD report, invalid, not available, allow.
    always_comb begin
        allow       = 1'b0;
        fault_valid = 1'b0;
        fault_vec   = '0;
        if (sse_exc && ctl.xmm) begin
            fault_valid = 1'b1;
            fault_vec   = VEC_XF;
        end else if (issue) begin
            if (ud) begin
                fault_valid = 1'b1;
                fault_vec   = VEC_UD;
            end else if (nm) begin
                fault_valid = 1'b1;
                fault_vec   = VEC_NM;
            end else begin
                allow = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpu_perm_gate.sv
// Top of the floating-point and vector permission gate.
// Joins the control-bit store to the verdict logic.
// Assumes at most one issue per cycle; outputs follow inputs in the same cycle.
module fpu_perm_gate
    import fpg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [2:0]       iclass,
    input  logic             task_sw,
    input  logic             clr_ts,
    input  logic             cr0_we,
    input  logic [XLEN-1:0]  cr0_wdata,
    input  logic             cr4_we,
    input  logic [XLEN-1:0]  cr4_wdata,
    input  logic             sse_exc,
    output logic             allow,
    output logic             fault_valid,
    output logic [7:0]       fault_vec
);
    ctl_t ctl;

    fpg_ctrl_regs #(.XLEN(XLEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .task_sw(task_sw), .clr_ts(clr_ts),
        .cr0_we(cr0_we), .cr0_wdata(cr0_wdata), .cr4_we(cr4_we),
        .cr4_wdata(cr4_wdata), .sse_exc(sse_exc), .ctl(ctl)
    );

    fpg_decide u_decide (
        .issue(issue), .iclass(iclass), .sse_exc(sse_exc), .ctl(ctl),
        .allow(allow), .fault_valid(fault_valid), .fault_vec(fault_vec)
    );

    // R10
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(allow && fault_valid));
    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !sse_exc) |-> (!allow && !fault_valid));
    // R2
    em_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !sse_exc && ctl.em && iclass == 3'd0) |-> (fault_valid && fault_vec == VEC_UD));
    // R4
    wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !sse_exc && iclass == 3'd1 && !ctl.ts) |-> allow);
    // R8
    simd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sse_exc && ctl.xmm) |-> (fault_valid && fault_vec == VEC_XF && !allow));
endmodule

// File: tb/fpu_perm_gate_bench.sv
`timescale 1ns/1ps
module fpu_perm_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [2:0]  iclass = '0;
    logic        task_sw = 1'b0, clr_ts = 1'b0, cr0_we = 1'b0, cr4_we = 1'b0, sse_exc = 1'b0;
    logic [31:0] cr0_wdata = '0, cr4_wdata = '0;
    logic        allow, fault_valid;
    logic [7:0]  fault_vec;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference state
    bit m_mp, m_em, m_ts, m_fx, m_xm, m_xs, m_off;

    always #2 clk = ~clk;

    fpu_perm_gate u_fpu_perm_gate (
        .clk(clk), .rst_n(rst_n), .issue(issue), .iclass(iclass),
        .task_sw(task_sw), .clr_ts(clr_ts), .cr0_we(cr0_we), .cr0_wdata(cr0_wdata),
        .cr4_we(cr4_we), .cr4_wdata(cr4_wdata), .sse_exc(sse_exc),
        .allow(allow), .fault_valid(fault_valid), .fault_vec(fault_vec)
    );

    task automatic model_clear();
        {m_mp, m_em, m_ts, m_fx, m_xm, m_xs, m_off} = '0;
    endtask

    // compare outputs to the model, then advance the model for the coming edge
    task automatic check_and_step(input string force_tag);
        bit    ea, ef;
        int    ev;
        string tag;
        ea = 0; ef = 0; ev = 0; tag = "R10";
        if (sse_exc && m_xm) begin
            ef = 1; ev = 19; tag = "R8";
        end else if (issue) begin
            if (iclass == 1) begin
                tag = "R4";
                if (m_mp && m_ts) begin ef = 1; ev = 7; end else ea = 1;
            end else if (iclass <= 4) begin
                if (m_em) begin ef = 1; ev = 6; tag = "R2"; end
                else if (iclass == 3 && !m_fx) begin ef = 1; ev = 6; tag = "R5"; end
                else if (iclass == 3 && m_off) begin ef = 1; ev = 6; tag = "R9"; end
                else if (iclass == 4 && !m_xs) begin ef = 1; ev = 6; tag = "R6"; end
                else if (m_ts) begin ef = 1; ev = 7; tag = "R3"; end
                else ea = 1;
            end else ea = 1;
        end
        if (force_tag != "") tag = force_tag;
        checks++;
        if (allow !== ea || fault_valid !== ef || (ef && fault_vec !== ev[7:0])) begin
            fails++;
            $display("FAIL %s: allow/fault/vec = %0b/%0b/%0d expected %0b/%0b/%0d",
                     tag, allow, fault_valid, fault_vec, ea, ef, ev);
        end
        if (cr0_we) begin m_mp = cr0_wdata[1]; m_em = cr0_wdata[2]; end
        if (task_sw) m_ts = 1;
        else if (clr_ts) m_ts = 0;
        else if (cr0_we) m_ts = cr0_wdata[3];
        if (cr4_we) m_off = 0;
        else if (sse_exc && !m_xm) m_off = 1;
        if (cr4_we) begin m_fx = cr4_wdata[9]; m_xm = cr4_wdata[10]; m_xs = cr4_wdata[18]; end
    endtask

    task automatic cyc(input bit is, input int cl, input bit tsw, input bit clr,
                       input bit c0w, input logic [31:0] c0d,
                       input bit c4w, input logic [31:0] c4d,
                       input bit sx, input string tag);
        @(negedge clk);
        issue = is; iclass = cl[2:0]; task_sw = tsw; clr_ts = clr;
        cr0_we = c0w; cr0_wdata = c0d; cr4_we = c4w; cr4_wdata = c4d; sse_exc = sx;
        #1;
        check_and_step(tag);
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state per class
        for (int c = 0; c < 8; c++) cyc(1, c, 0, 0, 0, 0, 0, 0, 0, (c < 5) ? "R1" : "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        // enable SSE, exceptions and extended save
        cyc(0, 0, 0, 0, 0, 0, 1, 32'h0004_0600, 0, "R10");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R5");
        cyc(1, 4, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R2 EM with TS set too
        cyc(0, 0, 0, 0, 1, 32'h0000_000C, 0, 0, 0, "R2");
        for (int c = 0; c < 5; c++) cyc(1, c, 0, 0, 0, 0, 0, 0, 0, (c == 1) ? "R4" : "R2");
        // R3 / R4 TS with MP
        cyc(0, 0, 0, 0, 1, 32'h0000_000A, 0, 0, 0, "R3");
        for (int c = 0; c < 5; c++) cyc(1, c, 0, 0, 0, 0, 0, 0, 0, (c == 1) ? "R4" : "R3");
        cyc(0, 0, 0, 0, 1, 32'h0000_0008, 0, 0, 0, "R4");
        cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R7 strobes and priorities
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 1, 1, 32'h0000_0008, 0, 0, 0, "R7");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
        cyc(0, 0, 1, 1, 1, 32'h0, 0, 0, 0, "R7");
        cyc(1, 2, 0, 0, 0, 0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, "R7");
        // R8 SIMD report over a concurrent issue
        cyc(1, 3, 0, 0, 0, 0, 0, 0, 1, "R8");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R9 latch path
        cyc(0, 0, 0, 0, 0, 0, 1, 32'h0000_0200, 0, "R9");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, 1, "R9");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R9");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, 0, 0, 1, 32'h0000_0200, 1, "R9");
        cyc(1, 3, 0, 0, 0, 0, 0, 0, 0, "R9");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [31:0] d0, d4;
            r = $urandom_range(0, 99);
            d0 = $urandom & 32'h0000_000E;
            d4 = $urandom & 32'h0004_0600;
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7),
                r < 4, (r >= 4 && r < 9), (r >= 9 && r < 14), d0,
                (r >= 14 && r < 18), d4, $urandom_range(0, 19) == 0, "");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule